// File: doc/BRIEF.md
# Keystream candidate state verifier

This block decides whether a complete 64-bit register state of the three-register majority-clocked stream generator reproduces a known keystream segment. A caller hands it one candidate (the 19-, 22- and 23-bit register contents as they stand after warm-up) together with the 64 known keystream bits. The block then advances the candidate with the irregular stop/go rule, one step per clock cycle, producing one keystream bit per step and comparing it with the known bit of the same index.

The check stops at the first contradiction and reports a reject carrying the index of the disagreeing bit. Only when all 64 bits agree is a pass reported. A reject therefore costs as few cycles as the contradiction allows, which matters when the block screens a large stream of candidates. An abort input drops the candidate in progress without any result.

Top module: `ks_candidate_checker`

## Requirements
- R1: `cand_ready` is high only while the block is idle and `abort` is low; a candidate is captured on a cycle with `cand_valid` and `cand_ready` both high, and `cand_ready` is low on the following cycle.
- R2: Each step computes the majority of bit 8 of the 19-bit register, bit 10 of the 22-bit register and bit 10 of the 23-bit register; exactly the registers whose clocking bit equals the majority advance, the others hold.
- R3: A register that advances shifts left by one, and bit 0 takes the XOR of its feedback taps: bits 18, 17, 16, 13 (19-bit), bits 21, 20 (22-bit), bits 22, 21, 20, 7 (23-bit).
- R4: The bit produced by a step is the XOR of bit 18, bit 21 and bit 22 of the three registers after that step; the first step's bit is compared with `cand_ks[0]`, the k-th step's with `cand_ks[k-1]`.
- R5: If the bit of index k is the first to disagree, `res_valid` rises exactly k+1 clock edges after the accepting edge with `res_pass` = 0 and `res_index` = k; later bits are not examined.
- R6: If all 64 bits agree, `res_valid` rises exactly 64 clock edges after the accepting edge with `res_pass` = 1 and `res_index` = 64.
- R7: `res_valid` is a single-cycle pulse per accepted candidate; the block is idle in the pulse cycle.
- R8: `abort` high at a clock edge returns the block to idle and no result is ever produced for the aborted candidate.
- R9: After reset `res_valid` is low and `cand_ready` is high.
- R10: `cand_valid` and candidate data presented while a check is running have no effect on the result of that check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Synchronous abort to idle, no result |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Block idle and able to take a candidate |
| cand_ra | input | 19 | 19-bit register contents of the candidate |
| cand_rb | input | 22 | 22-bit register contents of the candidate |
| cand_rc | input | 23 | 23-bit register contents of the candidate |
| cand_ks | input | 64 | Known keystream, bit k is index k |
| res_valid | output | 1 | One-cycle result pulse |
| res_pass | output | 1 | 1 when all bits matched |
| res_index | output | 7 | First mismatch index, 64 on a pass |

## Verification
The hardest situation to reach is a contradiction on the very last bit, index 63, since it needs a candidate whose first 63 bits match exactly; the bench reaches it, and every other chosen mismatch position, by computing the true 64-bit stream of each candidate from the stepping rules and then flipping a chosen bit of it. Several flips in one segment show that only the earliest is reported. An all-ones and an all-zero state exercise the rule where all three registers advance together, and a mixed state exercises the two-of-three cases.

// File: rtl/ks_chk_pkg.sv
// Shared constants for the keystream candidate verifier.
// Assumes the three register lengths and tap sets are fixed by the generator.
package ks_chk_pkg;
    localparam int RA_LEN = 19;
    localparam int RB_LEN = 22;
    localparam int RC_LEN = 23;

    localparam logic [RA_LEN-1:0] RA_TAPS = RA_LEN'((1 << 18) | (1 << 17) | (1 << 16) | (1 << 13));
    localparam logic [RB_LEN-1:0] RB_TAPS = RB_LEN'((1 << 21) | (1 << 20));
    localparam logic [RC_LEN-1:0] RC_TAPS = RC_LEN'((1 << 22) | (1 << 21) | (1 << 20) | (1 << 7));

    localparam int RA_CLK = 8;
    localparam int RB_CLK = 10;
    localparam int RC_CLK = 10;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} chk_state_t;
endpackage

// File: rtl/ks_lfsr_stage.sv
// One stop/go shift register of the generator.
// Loads a full value on load_i; on step_i with go_i it shifts left and
// inserts the XOR of the tap bits at bit 0. Reports its clocking bit and the
// MSB it will have after the current step.
module ks_lfsr_stage #(
    parameter int            LEN      = 19,
    parameter logic [LEN-1:0] TAP_MASK = '0,
    parameter int            CLK_BIT  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [LEN-1:0] load_val_i,
    input  logic           step_i,
    input  logic           go_i,
    output logic           clk_bit_o,
    output logic           next_msb_o
);
    logic [LEN-1:0] sr_q;
    logic           fb;

    // Feedback bit and stage outputs.
    always_comb begin
        fb         = ^(sr_q & TAP_MASK);
        clk_bit_o  = sr_q[CLK_BIT];
        next_msb_o = go_i ? sr_q[LEN-2] : sr_q[LEN-1];
    end

    // Register load and conditional shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q <= load_val_i;
        end else if (step_i && go_i) begin
            sr_q <= {sr_q[LEN-2:0], fb};
        end
    end
endmodule

// File: rtl/ks_majority.sv
// Stop/go decision: a register advances when its clocking bit equals the
// majority of the three clocking bits. Purely combinational.
module ks_majority (
    input  logic [2:0] cbit_i,
    output logic [2:0] go_o
);
    logic maj;

    // Majority vote and per-register agreement.
    always_comb begin
        maj = (cbit_i[0] & cbit_i[1]) | (cbit_i[0] & cbit_i[2]) | (cbit_i[1] & cbit_i[2]);
        for (int i = 0; i < 3; i++) begin
            go_o[i] = (cbit_i[i] == maj);
        end
    end
endmodule

// File: rtl/ks_candidate_checker.sv
// Verifies one complete register state against a known keystream segment.
// One generator step per cycle; stops at the first disagreeing bit.
// Assumes the caller holds candidate data stable while cand_valid is high.
module ks_candidate_checker
    import ks_chk_pkg::*;
#(
    parameter int KS_LEN = 64,
    localparam int IDX_W = $clog2(KS_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              cand_valid,
    output logic              cand_ready,
    input  logic [RA_LEN-1:0] cand_ra,
    input  logic [RB_LEN-1:0] cand_rb,
    input  logic [RC_LEN-1:0] cand_rc,
    input  logic [KS_LEN-1:0] cand_ks,
    output logic              res_valid,
    output logic              res_pass,
    output logic [IDX_W-1:0]  res_index
);
    chk_state_t        state_q;
    logic [KS_LEN-1:0] ks_q;
    logic [IDX_W-1:0]  idx_q;
    logic              accept;
    logic              step;
    logic [2:0]        cbits;
    logic [2:0]        go;
    logic [2:0]        msbs;
    logic              gen_bit;
    logic              mismatch;
    logic              last_bit;

    // Handshake and step control.
    always_comb begin
        cand_ready = (state_q == ST_IDLE) && !abort;
        accept     = cand_valid && cand_ready;
        step       = (state_q == ST_RUN) && !abort;
        gen_bit    = ^msbs;
        mismatch   = gen_bit != ks_q[0];
        last_bit   = idx_q == IDX_W'(KS_LEN - 1);
    end

    ks_majority u_maj (
        .cbit_i (cbits),
        .go_o   (go)
    );

    ks_lfsr_stage #(.LEN(RA_LEN), .TAP_MASK(RA_TAPS), .CLK_BIT(RA_CLK)) u_ra (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (cand_ra),
        .step_i     (step),
        .go_i       (go[0]),
        .clk_bit_o  (cbits[0]),
        .next_msb_o (msbs[0])
    );

    ks_lfsr_stage #(.LEN(RB_LEN), .TAP_MASK(RB_TAPS), .CLK_BIT(RB_CLK)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (cand_rb),
        .step_i     (step),
        .go_i       (go[1]),
        .clk_bit_o  (cbits[1]),
        .next_msb_o (msbs[1])
    );

    ks_lfsr_stage #(.LEN(RC_LEN), .TAP_MASK(RC_TAPS), .CLK_BIT(RC_CLK)) u_rc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (cand_rc),
        .step_i     (step),
        .go_i       (go[2]),
        .clk_bit_o  (cbits[2]),
        .next_msb_o (msbs[2])
    );

    // Control state, keystream shifter, bit index and result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ks_q      <= '0;
            idx_q     <= '0;
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_index <= '0;
        end else begin
            res_valid <= 1'b0;
            if (abort) begin
                state_q <= ST_IDLE;
            end else if (state_q == ST_IDLE) begin
                if (accept) begin
                    ks_q    <= cand_ks;
                    idx_q   <= '0;
                    state_q <= ST_RUN;
                end
            end else if (mismatch) begin
                res_valid <= 1'b1;
                res_pass  <= 1'b0;
                res_index <= idx_q;
                state_q   <= ST_IDLE;
            end else if (last_bit) begin
                res_valid <= 1'b1;
                res_pass  <= 1'b1;
                res_index <= IDX_W'(KS_LEN);
                state_q   <= ST_IDLE;
            end else begin
                idx_q <= idx_q + 1'b1;
                ks_q  <= ks_q >> 1;
            end
        end
    end
endmodule

// File: rtl/ks_candidate_checker_sva.sv
// Port-level protocol checks for the candidate verifier, attached by bind.
// Tracks ownership of a check from the accepting edge to its result or abort.
module ks_candidate_checker_sva #(
    parameter int KS_LEN = 64,
    localparam int IDX_W = $clog2(KS_LEN + 1),
    localparam int CNT_W = $clog2(KS_LEN + 4)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             cand_valid,
    input logic             cand_ready,
    input logic             res_valid,
    input logic             res_pass,
    input logic [IDX_W-1:0] res_index
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Shadow of an accepted, not yet finished candidate and its age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (cand_valid && cand_ready) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (res_valid || abort) begin
            busy_q <= 1'b0;
        end else if (busy_q && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_ready) |=> !cand_ready);

    assert_fail_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_pass) |-> (res_index < IDX_W'(KS_LEN)));

    assert_latency_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CNT_W'(KS_LEN + 1)));

    assert_pass_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass) |-> (res_index == IDX_W'(KS_LEN)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_idle_on_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !abort) |-> cand_ready);

    assert_abort_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !res_valid);

    assert_result_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy_q);
endmodule

bind ks_candidate_checker ks_candidate_checker_sva #(.KS_LEN(KS_LEN)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .cand_valid (cand_valid),
    .cand_ready (cand_ready),
    .res_valid  (res_valid),
    .res_pass   (res_pass),
    .res_index  (res_index)
);

// File: tb/ks_candidate_checker_tb.sv
module ks_candidate_checker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // Vector: {ra, rb, rc, flip_en, flip_idx}
    localparam logic [70:0] VECS [NVEC] = '{
        {19'h5A5A5, 22'h2C0FFE, 23'h3BEEF1, 1'b0, 6'd0},
        {19'h5A5A5, 22'h2C0FFE, 23'h3BEEF1, 1'b1, 6'd0},
        {19'h7FFFF, 22'h3FFFFF, 23'h7FFFFF, 1'b1, 6'd63},
        {19'h00001, 22'h000200, 23'h400401, 1'b1, 6'd31},
        {19'h00000, 22'h000000, 23'h000000, 1'b0, 6'd0},
        {19'h12345, 22'h0ABCDE, 23'h54321A, 1'b1, 6'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        cand_valid = 1'b0;
    logic        cand_ready;
    logic [18:0] cand_ra = '0;
    logic [21:0] cand_rb = '0;
    logic [22:0] cand_rc = '0;
    logic [63:0] cand_ks = '0;
    logic        res_valid;
    logic        res_pass;
    logic [6:0]  res_index;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ks_candidate_checker u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (abort),
        .cand_valid (cand_valid),
        .cand_ready (cand_ready),
        .cand_ra    (cand_ra),
        .cand_rb    (cand_rb),
        .cand_rc    (cand_rc),
        .cand_ks    (cand_ks),
        .res_valid  (res_valid),
        .res_pass   (res_pass),
        .res_index  (res_index)
    );

    // Reference stream from the stepping rules of R2, R3, R4.
    function automatic logic [63:0] model_ks(input logic [18:0] a0, input logic [21:0] b0,
                                             input logic [22:0] c0);
        logic [18:0] a = a0;
        logic [21:0] b = b0;
        logic [22:0] c = c0;
        logic [63:0] out = '0;
        for (int k = 0; k < 64; k++) begin
            logic m;
            m = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
            if (a[8] == m) a = {a[17:0], a[18] ^ a[17] ^ a[16] ^ a[13]};
            if (b[10] == m) b = {b[20:0], b[21] ^ b[20]};
            if (c[10] == m) c = {c[21:0], c[22] ^ c[21] ^ c[20] ^ c[7]};
            out[k] = a[18] ^ b[21] ^ c[22];
        end
        return out;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Offer a candidate, wait for its result, check pass, index and latency.
    task automatic run_cand(input logic [18:0] a, input logic [21:0] b, input logic [22:0] c,
                            input logic [63:0] ks, input bit exp_pass, input int exp_idx,
                            input string req);
        int lat = 0;
        int exp_lat = exp_pass ? 64 : exp_idx + 1;
        @(negedge clk);
        cand_ra = a; cand_rb = b; cand_rc = c; cand_ks = ks;
        cand_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cand_valid = 1'b0;
        check(cand_ready == 1'b0, "R1", "ready low after accept", cand_ready, 0);
        while (lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (res_valid) break;
        end
        check(res_valid == 1'b1, req, "result seen", res_valid, 1);
        check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(res_pass == exp_pass, req, "pass flag", res_pass, exp_pass);
        check(res_index == 7'(exp_idx), req, "index", res_index, exp_idx);
        @(negedge clk);
        check(res_valid == 1'b0, "R7", "single pulse", res_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(res_valid == 1'b0, "R9", "res_valid in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R9", "res_valid after reset", res_valid, 0);
        check(cand_ready == 1'b1, "R9", "ready after reset", cand_ready, 1);

        // Vector table: pass cases cover R2, R3, R4, R6; flips cover R5
        for (int v = 0; v < NVEC; v++) begin
            logic [63:0] ks;
            logic [70:0] e = VECS[v];
            ks = model_ks(e[70:52], e[51:30], e[29:7]);
            if (e[6]) begin
                ks[e[5:0]] = ~ks[e[5:0]];
                run_cand(e[70:52], e[51:30], e[29:7], ks, 1'b0, int'(e[5:0]), "R5");
            end else begin
                run_cand(e[70:52], e[51:30], e[29:7], ks, 1'b1, 64, "R6");
            end
        end

        // R5: two flips, only the earlier one reported
        begin
            logic [63:0] ks = model_ks(19'h3C3C3, 22'h155555, 23'h2AAAAA);
            ks[40] = ~ks[40];
            ks[50] = ~ks[50];
            run_cand(19'h3C3C3, 22'h155555, 23'h2AAAAA, ks, 1'b0, 40, "R5");
        end

        // R4: whole stream inverted, first bit rejects
        run_cand(19'h0F0F0, 22'h0F0F0F, 23'h70F0F0,
                 ~model_ks(19'h0F0F0, 22'h0F0F0F, 23'h70F0F0), 1'b0, 0, "R4");

        // R8: abort mid-run, no result
        begin
            bit seen = 1'b0;
            @(negedge clk);
            cand_ra = 19'h5A5A5; cand_rb = 22'h2C0FFE; cand_rc = 23'h3BEEF1;
            cand_ks = model_ks(19'h5A5A5, 22'h2C0FFE, 23'h3BEEF1);
            cand_valid = 1'b1;
            @(negedge clk);
            cand_valid = 1'b0;
            repeat (10) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (res_valid) seen = 1'b1;
            end
            check(seen == 1'b0, "R8", "no result after abort", seen, 0);
            check(cand_ready == 1'b1, "R8", "idle after abort", cand_ready, 1);
        end

        // R1: abort held with valid in idle blocks acceptance
        @(negedge clk);
        abort = 1'b1;
        cand_valid = 1'b1;
        #1;
        check(cand_ready == 1'b0, "R1", "ready low during abort", cand_ready, 1'b0);
        @(negedge clk);
        cand_valid = 1'b0;
        abort = 1'b0;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 70; k++) begin
                @(negedge clk);
                if (res_valid) seen = 1'b1;
            end
            check(seen == 1'b0, "R1", "nothing accepted under abort", seen, 0);
        end

        // R10: new candidate offered during a run is ignored
        begin
            logic [63:0] ks = model_ks(19'h12345, 22'h0ABCDE, 23'h54321A);
            int lat = 0;
            ks[20] = ~ks[20];
            @(negedge clk);
            cand_ra = 19'h12345; cand_rb = 22'h0ABCDE; cand_rc = 23'h54321A; cand_ks = ks;
            cand_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            cand_ra = 19'h00000; cand_rb = '0; cand_rc = '0; cand_ks = '0;
            while (lat < 100) begin
                @(posedge clk);
                lat++;
                @(negedge clk);
                if (lat == 10) cand_valid = 1'b0;
                if (res_valid) break;
            end
            check(res_pass == 1'b0 && res_index == 7'd20, "R10", "index unaffected",
                  res_index, 20);
            check(lat == 21, "R10", "latency unaffected", lat, 21);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule